// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Date Alarm

This block keeps the date and time of day as six BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year covering 2000 to 2099. A prescaler counts a 32768 Hz reference enable. Every `TICKS_PER_SEC` enables, it moves the calendar forward one second, with BCD carries running from field to field.

The block also emits single-cycle event pulses for each elapsed second, minute, hour and day. An alarm event fires when the calendar, after a one-second update, equals all six alarm bytes exactly. The alarm has no masked fields.

A busy output marks the reference period just before each update, so software can avoid that window. Time and alarm bytes are written through per-field load strobes that share a data bus. The `run` input starts and freezes the count.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day 01, month 01, year 00. All event pulses and busy are low.
- R2: While `run` is high, the calendar advances one second for every `TICKS_PER_SEC` cycles in which `ref_en` is high, and `ev_sec` pulses for one cycle in the cycle that shows the new time.
- R3: `busy` is high from the reference enable that leaves one enable to go until the clock edge that performs the update. That is exactly one reference period per second, and `ev_sec` is always preceded by a busy cycle.
- R4: Seconds roll 59→00 and carry into minutes; minutes roll 59→00 and carry into hours. `ev_min` pulses together with `ev_sec` when seconds become 00.
- R5: Hours roll 23→00 and carry into the day. `ev_hour` pulses when minutes wrap and `ev_day` pulses when hours wrap.
- R6: The day rolls to 01 and carries into the month after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R7: February ends at day 29 when the year (00..99) is divisible by four, including 00, and at day 28 otherwise.
- R8: The month rolls 12→01 and carries into the year; the year rolls 99→00.
- R9: While `run` is low, no field changes except by a load, no event pulses, and `busy` is low.
- R10: `ld_field` bit k (0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year) writes `ld_data` into that field at the next edge. In a cycle with any load bit set, the one-second advance due in that cycle is absorbed: no field carries and no event pulses.
- R11: `alarm_ev` pulses in the `ev_sec` cycle when all six fields equal their alarm bytes. A mismatch in any single field, the year included, suppresses it.
- R12: `alm_ld` bit k (same field order as R10) writes `alm_data` into that alarm byte and leaves the time fields untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable per 32768 Hz reference period |
| run | input | 1 | Count enable; low freezes the calendar |
| ld_field | input | 6 | Per-field time load strobes (0 sec … 5 year) |
| ld_data | input | 8 | BCD value for time loads |
| alm_ld | input | 6 | Per-field alarm load strobes (0 sec … 5 year) |
| alm_data | input | 8 | BCD value for alarm loads |
| t_sec | output | 8 | Seconds, BCD 00–59 |
| t_min | output | 8 | Minutes, BCD 00–59 |
| t_hour | output | 8 | Hours, BCD 00–23 |
| t_day | output | 8 | Day of month, BCD 01–31 |
| t_mon | output | 8 | Month, BCD 01–12 |
| t_year | output | 8 | Year within century, BCD 00–99 |
| ev_sec | output | 1 | Second elapsed pulse |
| ev_min | output | 1 | Minute elapsed pulse |
| ev_hour | output | 1 | Hour elapsed pulse |
| ev_day | output | 1 | Day elapsed pulse |
| alarm_ev | output | 1 | Full-date alarm match pulse |
| busy | output | 1 | Update window indicator |

## Verification
The main check loads the last second of the last day of every month across years 00 to 04, 98 and 99, then takes one step. This separates the 30-day, 31-day, 28-day and 29-day lengths, the leap-year test (including year 00) and the year wrap. Steps that stop at a seconds-only, minute or hour carry show that each event pulse appears only at its own boundary. Running the reference enable continuously and then every other cycle tells the prescaler period apart from the busy window width. The alarm runs twice, once with an exact match and once where only the year differs, which shows that the year takes part in the comparison.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int NFIELD = 6;
   localparam int FW     = 8;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;

   typedef logic [NFIELD-1:0][FW-1:0] cal_vec_t;

   // add one to a two-digit BCD value (no range wrap here)
   function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
      logic [FW-1:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // last day of a month as BCD; leap test on the BCD year
   function automatic logic [FW-1:0] month_len(input logic [FW-1:0] mon,
                                               input logic [FW-1:0] yr);
      logic [2:0]    s;
      logic          leap;
      logic [FW-1:0] r;
      // tens*10 mod 4 equals 2*(tens odd); add units mod 4
      s    = {1'b0, yr[4], 1'b0} + {1'b0, yr[1:0]};
      leap = (s[1:0] == 2'b00);
      case (mon)
         8'h02:                      r = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ref_en,
   output logic tick_o,
   output logic busy_o
);
   localparam int            CW   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
   localparam bit            POW2 = ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;
   logic          at_last;

   generate
      if (POW2) begin : g_pow2
         assign cnt_nxt = cnt + 1'b1;
      end else begin : g_cmp
         assign cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (run && ref_en)  cnt <= cnt_nxt;
   end

   assign at_last = (cnt == LAST);
   assign busy_o  = run & at_last;
   assign tick_o  = run & ref_en & at_last;

   p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt == '0));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter logic [7:0] RST_VAL = 8'h00,
   parameter logic [7:0] MIN_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_i,
   input  logic [7:0] ld_val_i,
   input  logic       cin_i,
   input  logic [7:0] max_i,
   output logic [7:0] q_o,
   output logic       cout_o
);
   import rtc_cal_pkg::*;

   logic wrap;

   // >= so an out-of-range loaded value still wraps
   assign wrap   = (q_o >= max_i);
   assign cout_o = cin_i & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (ld_i)  q_o <= ld_val_i;
      else if (cin_i) q_o <= wrap ? MIN_VAL : bcd_inc(q_o);
   end

   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (q_o == $past(ld_val_i)));
   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cin_i && !ld_i) |=> $stable(q_o));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFIELD-1:0] ld_i,
   input  logic [FW-1:0]     data_i,
   input  cal_vec_t          cur_i,
   input  logic              upd_i,
   output logic              hit_o
);
   cal_vec_t          alm;
   logic [NFIELD-1:0] eq;

   generate
      for (genvar gi = 0; gi < NFIELD; gi++) begin : g_alm
         localparam logic [FW-1:0] ARST = (gi == F_DAY || gi == F_MON) ? 8'h01 : 8'h00;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      alm[gi] <= ARST;
            else if (ld_i[gi]) alm[gi] <= data_i;
         end
         assign eq[gi] = (cur_i[gi] == alm[gi]);
      end
   endgenerate

   // every field must match: no masking
   assign hit_o = upd_i & (&eq);

   p_alm_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i[F_YEAR] |=> (alm[F_YEAR] == $past(data_i)));
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic       run,
   input  logic [5:0] ld_field,
   input  logic [7:0] ld_data,
   input  logic [5:0] alm_ld,
   input  logic [7:0] alm_data,
   output logic [7:0] t_sec,
   output logic [7:0] t_min,
   output logic [7:0] t_hour,
   output logic [7:0] t_day,
   output logic [7:0] t_mon,
   output logic [7:0] t_year,
   output logic       ev_sec,
   output logic       ev_min,
   output logic       ev_hour,
   output logic       ev_day,
   output logic       alarm_ev,
   output logic       busy
);
   import rtc_cal_pkg::*;

   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_ticks
         $error("TICKS_PER_SEC must be at least 2");
      end
   endgenerate

   logic          sec_tick;
   logic          adv;
   logic [NFIELD:0] chain;
   cal_vec_t      cur;
   cal_vec_t      fmax;
   logic [3:0]    ev_q;

   rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .ref_en (ref_en),
      .tick_o (sec_tick),
      .busy_o (busy)
   );

   // a load in the same cycle absorbs the pending advance
   assign adv      = sec_tick & ~(|ld_field);
   assign chain[0] = adv;

   always_comb begin
      fmax[F_SEC]  = 8'h59;
      fmax[F_MIN]  = 8'h59;
      fmax[F_HOUR] = 8'h23;
      fmax[F_DAY]  = month_len(cur[F_MON], cur[F_YEAR]);
      fmax[F_MON]  = 8'h12;
      fmax[F_YEAR] = 8'h99;
   end

   generate
      for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
         localparam logic [FW-1:0] FMIN = (gi == F_DAY || gi == F_MON) ? 8'h01 : 8'h00;
         rtc_bcd_field #(.RST_VAL(FMIN), .MIN_VAL(FMIN)) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (ld_field[gi]),
            .ld_val_i (ld_data),
            .cin_i    (chain[gi]),
            .max_i    (fmax[gi]),
            .q_o      (cur[gi]),
            .cout_o   (chain[gi+1])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= {chain[3], chain[2], chain[1], adv};
   end

   assign ev_sec  = ev_q[0];
   assign ev_min  = ev_q[1];
   assign ev_hour = ev_q[2];
   assign ev_day  = ev_q[3];

   rtc_alarm_match u_alm (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (alm_ld),
      .data_i (alm_data),
      .cur_i  (cur),
      .upd_i  (ev_sec),
      .hit_o  (alarm_ev)
   );

   assign t_sec  = cur[F_SEC];
   assign t_min  = cur[F_MIN];
   assign t_hour = cur[F_HOUR];
   assign t_day  = cur[F_DAY];
   assign t_mon  = cur[F_MON];
   assign t_year = cur[F_YEAR];

   p_evsec_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sec |-> $past(busy));
   p_evmin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_min |-> (ev_sec && t_sec == 8'h00));
   p_evday_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_day |-> (ev_hour && t_hour == 8'h00));
   p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chain[NFIELD] |=> (t_year == 8'h00));
   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ev_sec);
   p_absorb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|ld_field) |=> !ev_sec);
   p_alarm_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_ev |-> ev_sec);
endmodule

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;
   localparam int TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic       run = 1'b0;
   logic [5:0] ld_field = '0;
   logic [7:0] ld_data = '0;
   logic [5:0] alm_ld = '0;
   logic [7:0] alm_data = '0;
   logic [7:0] t_sec, t_min, t_hour, t_day, t_mon, t_year;
   logic       ev_sec, ev_min, ev_hour, ev_day, alarm_ev, busy;

   int  errors = 0;
   int  checks = 0;
   int  ref_mode = 0;
   bit  done = 1'b0;

   bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) dut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .run(run),
      .ld_field(ld_field), .ld_data(ld_data), .alm_ld(alm_ld), .alm_data(alm_data),
      .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_day(t_day),
      .t_mon(t_mon), .t_year(t_year), .ev_sec(ev_sec), .ev_min(ev_min),
      .ev_hour(ev_hour), .ev_day(ev_day), .alarm_ev(alarm_ev), .busy(busy)
   );

   always #5 clk = ~clk;

   // reference enable: every cycle (mode 0) or every other cycle (mode 1)
   initial forever begin
      @(negedge clk);
      if (ref_mode == 0) ref_en = 1'b1;
      else               ref_en = ~ref_en;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int mdays(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_time(input string req, input int y, input int mo, input int d,
                           input int h, input int mi, input int s);
      chk(req, "sec",   t_sec,  to_bcd(s));
      chk(req, "min",   t_min,  to_bcd(mi));
      chk(req, "hour",  t_hour, to_bcd(h));
      chk(req, "day",   t_day,  to_bcd(d));
      chk(req, "month", t_mon,  to_bcd(mo));
      chk(req, "year",  t_year, to_bcd(y));
   endtask

   task automatic step_model(inout int y, inout int mo, inout int d,
                             inout int h, inout int mi, inout int s);
      s++;
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      if (h == 24) begin h = 0; d++; end
      if (d > mdays(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y++; end
      if (y == 100) y = 0;
   endtask

   task automatic set_time(input int y, input int mo, input int d,
                           input int h, input int mi, input int s);
      int v[6];
      v[0] = s; v[1] = mi; v[2] = h; v[3] = d; v[4] = mo; v[5] = y;
      for (int k = 0; k < 6; k++) begin
         ld_field = 6'(1 << k);
         ld_data  = to_bcd(v[k]);
         @(negedge clk);
      end
      ld_field = '0;
   endtask

   task automatic set_alarm(input int y, input int mo, input int d,
                            input int h, input int mi, input int s);
      int v[6];
      v[0] = s; v[1] = mi; v[2] = h; v[3] = d; v[4] = mo; v[5] = y;
      for (int k = 0; k < 6; k++) begin
         alm_ld   = 6'(1 << k);
         alm_data = to_bcd(v[k]);
         @(negedge clk);
      end
      alm_ld = '0;
   endtask

   task automatic wait_sec(input string req);
      int n = 0;
      bit got = 1'b0;
      while (!got && n < 64) begin
         @(negedge clk);
         n++;
         if (ev_sec) got = 1'b1;
      end
      if (!got) chk(req, "ev_sec seen", 0, 1);
   endtask

   // one step from (y,mo,d,h,mi,s); checks fields and carries
   task automatic one_step(input string req, input int y, input int mo, input int d,
                           input int h, input int mi, input int s);
      int ey = y, emo = mo, ed = d, eh = h, emi = mi, es = s;
      step_model(ey, emo, ed, eh, emi, es);
      set_time(y, mo, d, h, mi, s);
      run = 1'b1;
      wait_sec(req);
      run = 1'b0;
      chk_time(req, ey, emo, ed, eh, emi, es);
      chk("R4", "ev_min",  ev_min,  (es == 0) ? 1 : 0);
      chk("R5", "ev_hour", ev_hour, (es == 0 && emi == 0) ? 1 : 0);
      chk("R5", "ev_day",  ev_day,  (es == 0 && emi == 0 && eh == 0) ? 1 : 0);
      @(negedge clk);
   endtask

   task automatic measure(input string req, input int exp_n, input int exp_b);
      int n = 0, b = 0;
      bit got = 1'b0;
      while (!got && n < 64) begin
         @(negedge clk);
         n++;
         if (busy) b++;
         if (ev_sec) got = 1'b1;
      end
      chk(req, "cycles per second", n, exp_n);
      chk("R3", "busy cycles per second", b, exp_b);
   endtask

   initial begin
      int yrs[7];
      logic [7:0] s0;
      bit bad;
      logic [47:0] snap;
      yrs[0] = 0; yrs[1] = 1; yrs[2] = 2; yrs[3] = 3; yrs[4] = 4; yrs[5] = 98; yrs[6] = 99;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_time("R1", 0, 1, 1, 0, 0, 0);
      chk("R1", "events", {ev_sec, ev_min, ev_hour, ev_day, alarm_ev}, 0);
      chk("R1", "busy", busy, 0);

      // R2 / R3: prescaler period and busy width at two reference rates
      set_time(3, 6, 15, 10, 20, 30);
      run = 1'b1;
      wait_sec("R2");
      chk("R2", "sec after first tick", t_sec, 8'h31);
      measure("R2", TPS, 1);
      chk("R2", "sec after second tick", t_sec, 8'h32);
      ref_mode = 1;
      wait_sec("R2");
      measure("R2", 2 * TPS, 2);
      run = 1'b0;
      ref_mode = 0;
      @(negedge clk);

      // R9: frozen while run low
      snap = {t_sec, t_min, t_hour, t_day, t_mon, t_year};
      bad = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (ev_sec || ev_min || ev_hour || ev_day || busy) bad = 1'b1;
         if ({t_sec, t_min, t_hour, t_day, t_mon, t_year} != snap) bad = 1'b1;
      end
      chk("R9", "no change while stopped", bad, 0);

      // R12: alarm loads leave the time alone
      set_alarm(11, 11, 11, 11, 11, 11);
      chk("R12", "time unchanged", {t_sec, t_min, t_hour, t_day, t_mon, t_year}, snap);
      chk("R12", "no alarm", alarm_ev, 0);

      // R4 / R5 individual carries
      one_step("R2", 3, 6, 15, 10, 20, 30);
      one_step("R4", 3, 6, 15, 10, 20, 59);
      one_step("R5", 3, 6, 15, 10, 59, 59);
      one_step("R7", 4, 2, 28, 23, 59, 59);
      one_step("R7", 1, 2, 28, 23, 59, 59);

      // R6 / R7 / R8 sweep of month ends
      foreach (yrs[i]) begin
         for (int mo = 1; mo <= 12; mo++) begin
            string rq;
            if (mo == 12)     rq = "R8";
            else if (mo == 2) rq = "R7";
            else              rq = "R6";
            one_step(rq, yrs[i], mo, mdays(mo, yrs[i]), 23, 59, 59);
         end
      end

      // R10: load during the update cycle absorbs the advance
      set_time(3, 6, 15, 10, 20, 30);
      run = 1'b1;
      begin
         int n = 0;
         while (!busy && n < 64) begin @(negedge clk); n++; end
      end
      s0 = t_sec;
      ld_field = 6'b000010;
      ld_data  = 8'h42;
      @(negedge clk);
      ld_field = '0;
      chk("R10", "no ev_sec on load cycle", ev_sec, 0);
      chk("R10", "min loaded", t_min, 8'h42);
      chk("R10", "sec held", t_sec, s0);
      wait_sec("R10");
      run = 1'b0;
      chk("R10", "sec resumes", t_sec, to_bcd(from_bcd(s0) + 1));
      chk("R10", "min kept", t_min, 8'h42);
      @(negedge clk);

      // R11: exact match, then a year-only mismatch
      set_alarm(99, 12, 31, 23, 59, 59);
      set_time(99, 12, 31, 23, 59, 58);
      run = 1'b1;
      wait_sec("R11");
      chk("R11", "alarm on exact match", alarm_ev, 1);
      wait_sec("R8");
      run = 1'b0;
      chk("R11", "no alarm next second", alarm_ev, 0);
      chk("R8", "year wraps", t_year, 8'h00);
      @(negedge clk);

      set_alarm(51, 6, 15, 12, 0, 1);
      set_time(50, 6, 15, 12, 0, 0);
      run = 1'b1;
      wait_sec("R11");
      run = 1'b0;
      chk("R11", "year mismatch blocks alarm", alarm_ev, 0);
      @(negedge clk);
      alm_ld = 6'b100000;
      alm_data = 8'h50;
      @(negedge clk);
      alm_ld = '0;
      set_time(50, 6, 15, 12, 0, 0);
      run = 1'b1;
      wait_sec("R11");
      run = 1'b0;
      chk("R11", "alarm after year fixed", alarm_ev, 1);
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule